// File: doc/BRIEF.md
# Interrupt Source Event-State Controller

This block holds a two-bit coalescing state for each of a small, parameterized number of interrupt sources that are triggered by message writes or by software. Software and devices never write the state directly. The operation is chosen by the kind of access (load or store), by which of the source's two pages is hit (trigger page or end-of-interrupt page), and by the offset inside that page. The data carried by an access plays no part.

The state has two bits. The pending bit (P) marks an event that has been sent onward and not yet retired. The queued bit (Q) marks a further event that arrived while P was set. The combination P=0, Q=1 is the masked state. When a trigger or an end-of-interrupt releases an event, the block raises a single-cycle forward pulse toward the downstream router, together with the index of the source. A load returns the state the source held before the access.

Top module: `esb_pq_ctrl`

## Requirements
- R1: After reset every source is in the masked state (P=0, Q=1), and `rsp_valid_o` and `fwd_o` are low.
- R2: A store to the trigger page fires the source. State 00 goes to 10 and forwards. State 10 goes to 11 without forwarding. State 11 stays 11. The masked state 01 stays 01 and does not forward.
- R3: A load at offset 0xC00 of the end-of-interrupt page sets the state to 00 and does not forward. A returned value with Q set tells software to re-trigger the source.
- R4: A load at offset 0xD00 of the end-of-interrupt page sets the state to the masked value 01.
- R5: A store at offset 0x400 of the end-of-interrupt page moves 10 to 00, and moves 11 to 10 while forwarding in the same operation. States 00 and 01 are left unchanged.
- R6: A load at offset 0x000 of the end-of-interrupt page makes the same state change and the same forward as R5.
- R7: A store to the end-of-interrupt page at any offset other than 0x400 has no effect. A load at any offset not named above, and any load of the trigger page, leaves the state unchanged. Stores never produce a response.
- R8: Every load raises `rsp_valid_o` for one cycle after the access clock edge. `rsp_pq_o` then carries the state held before the access, with P in bit 1 and Q in bit 0. A forward shows as `fwd_o` high for that same cycle, with `fwd_src_o` equal to the accessed source.
- R9: An access changes only the state of the source it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| wr_i | input | 1 | 1 = store, 0 = load |
| trig_page_i | input | 1 | 1 = trigger page, 0 = end-of-interrupt page |
| src_i | input | SRC_W | Source index |
| off_i | input | 12 | Offset within the page |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_pq_o | output | 2 | State before the load, {P,Q} |
| fwd_o | output | 1 | Forward-event pulse |
| fwd_src_o | output | SRC_W | Source of the forwarded event |

## Verification
On every cycle the assertions check the response protocol: a load is answered one cycle later and a store never is. They also check that the answer equals the state held before the access, that a forward names the source that was just accessed, that a trigger on a masked source forwards nothing, and that the mask load leaves the source masked. The full coalescing sequences can only be shown by the bench scenarios. These sequences are a chain of duplicate triggers collapsing into Q, a store or load end-of-interrupt that releases the queued event, and a software end-of-interrupt whose Q result leads to a re-trigger. The scenarios also show that accesses to one source leave the others untouched.

// File: rtl/esb_pkg.sv
package esb_pkg;
  localparam int OFF_W = 12;
  localparam logic [OFF_W-1:0] OFF_EOI_LD = 12'h000;
  localparam logic [OFF_W-1:0] OFF_EOI_ST = 12'h400;
  localparam logic [OFF_W-1:0] OFF_UNMASK = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_MASK   = 12'hD00;
  localparam logic [1:0] PQ_IDLE = 2'b00;
  localparam logic [1:0] PQ_OFF  = 2'b01;
  localparam logic [1:0] PQ_PEND = 2'b10;
  localparam logic [1:0] PQ_QUE  = 2'b11;

  typedef enum logic [2:0] {
    OP_NONE, OP_TRIG, OP_UNMASK, OP_MASK, OP_EOI_LD, OP_EOI_ST, OP_PEEK
  } esb_op_e;
endpackage

// File: rtl/esb_decode.sv
module esb_decode
  import esb_pkg::*;
(
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             trig_page_i,
  input  logic [OFF_W-1:0] off_i,
  output esb_op_e          op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (req_i) begin
      if (trig_page_i) begin
        op_o = wr_i ? OP_TRIG : OP_PEEK;
      end else if (wr_i) begin
        op_o = (off_i == OFF_EOI_ST) ? OP_EOI_ST : OP_NONE;
      end else begin
        unique case (off_i)
          OFF_EOI_LD: op_o = OP_EOI_LD;
          OFF_UNMASK: op_o = OP_UNMASK;
          OFF_MASK:   op_o = OP_MASK;
          default:    op_o = OP_PEEK;
        endcase
      end
    end
  end
endmodule

// File: rtl/esb_pq_cell.sv
module esb_pq_cell
  import esb_pkg::*;
(
  input  logic       sel_i,
  input  esb_op_e    op_i,
  input  logic [1:0] pq_i,
  output logic [1:0] pq_o,
  output logic       fwd_o
);
  always_comb begin
    pq_o  = pq_i;
    fwd_o = 1'b0;
    if (sel_i) begin
      unique case (op_i)
        OP_TRIG: begin
          if (pq_i == PQ_IDLE) begin
            pq_o  = PQ_PEND;
            fwd_o = 1'b1;
          end else if (pq_i == PQ_PEND) begin
            pq_o = PQ_QUE;
          end
        end
        OP_EOI_LD, OP_EOI_ST: begin
          // retire P; a queued event becomes the new pending one
          if (pq_i[1]) begin
            pq_o  = {pq_i[0], 1'b0};
            fwd_o = pq_i[0];
          end
        end
        OP_UNMASK: pq_o = PQ_IDLE;
        OP_MASK:   pq_o = PQ_OFF;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/esb_pq_ctrl.sv
module esb_pq_ctrl
  import esb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             trig_page_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_pq_o,
  output logic             fwd_o,
  output logic [SRC_W-1:0] fwd_src_o
);
  esb_op_e                  op;
  logic                     src_ok;
  logic [NUM_SRC-1:0][1:0]  pq_q, pq_d;
  logic [NUM_SRC-1:0]       cell_fwd;
  logic [1:0]               cur_pq;

  esb_decode i_decode (
    .req_i      (req_i),
    .wr_i       (wr_i),
    .trig_page_i(trig_page_i),
    .off_i      (off_i),
    .op_o       (op)
  );

  assign src_ok = ({1'b0, src_i} < (SRC_W+1)'(NUM_SRC));
  assign cur_pq = src_ok ? pq_q[src_i] : PQ_OFF;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    esb_pq_cell i_cell (
      .sel_i(src_ok && (src_i == SRC_W'(g))),
      .op_i (op),
      .pq_i (pq_q[g]),
      .pq_o (pq_d[g]),
      .fwd_o(cell_fwd[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pq_q[g] <= PQ_OFF;
      else         pq_q[g] <= pq_d[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_pq_o    <= PQ_OFF;
      fwd_o       <= 1'b0;
      fwd_src_o   <= '0;
    end else begin
      rsp_valid_o <= req_i && !wr_i && src_ok;
      if (req_i && !wr_i && src_ok) rsp_pq_o <= cur_pq;
      fwd_o <= |cell_fwd;
      if (|cell_fwd) fwd_src_o <= src_i;
    end
  end
endmodule

// File: rtl/esb_pq_chk.sv
module esb_pq_chk
  import esb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    wr_i,
  input logic                    trig_page_i,
  input logic [SRC_W-1:0]        src_i,
  input logic [OFF_W-1:0]        off_i,
  input logic                    rsp_valid_o,
  input logic [1:0]              rsp_pq_o,
  input logic                    fwd_o,
  input logic [SRC_W-1:0]        fwd_src_o,
  input logic [NUM_SRC-1:0][1:0] pq_q
);
  logic       in_rng;
  logic [1:0] sel_pq;
  assign in_rng = (int'(src_i) < NUM_SRC);
  assign sel_pq = in_rng ? pq_q[src_i] : 2'b01;

  a_r8_load_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wr_i && in_rng) |=> rsp_valid_o);
  a_r7_store_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i) |=> !rsp_valid_o);
  a_r8_rsp_prev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wr_i && in_rng) |=> (rsp_pq_o == $past(sel_pq)));
  a_r8_fwd_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> ($past(req_i) && fwd_src_o == $past(src_i)));
  a_r2_masked_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && trig_page_i && in_rng && sel_pq == 2'b01) |=> !fwd_o);
  a_r4_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wr_i && !trig_page_i && off_i == OFF_MASK && in_rng)
      |=> (pq_q[$past(src_i)] == 2'b01));
endmodule

bind esb_pq_ctrl esb_pq_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_esb_pq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i),
  .trig_page_i(trig_page_i), .src_i(src_i), .off_i(off_i),
  .rsp_valid_o(rsp_valid_o), .rsp_pq_o(rsp_pq_o), .fwd_o(fwd_o),
  .fwd_src_o(fwd_src_o), .pq_q(pq_q)
);

// File: tb/test_esb_pq_ctrl.sv
`timescale 1ns/1ps
module test_esb_pq_ctrl;
  localparam int N = 8;
  localparam int SW = 3;
  localparam logic [11:0] O_LD = 12'h000, O_ST = 12'h400, O_UM = 12'hC00,
                          O_MK = 12'hD00, O_PK = 12'h800;

  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0, tp = 0;
  logic [SW-1:0] src = '0;
  logic [11:0] off = '0;
  logic rsp_v, fwd;
  logic [1:0] rsp_pq;
  logic [SW-1:0] fwd_src;
  int n_chk = 0, n_err = 0;
  logic [1:0] exp_pq [N];

  always #2.5 clk = ~clk;

  esb_pq_ctrl #(.NUM_SRC(N)) i_esb_pq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .trig_page_i(tp),
    .src_i(src), .off_i(off), .rsp_valid_o(rsp_v), .rsp_pq_o(rsp_pq),
    .fwd_o(fwd), .fwd_src_o(fwd_src)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected {fwd, next_pq} from the requirements
  function automatic logic [2:0] model(input logic [1:0] pq, input logic w,
                                       input logic t, input logic [11:0] o);
    logic [1:0] nx = pq;
    logic f = 1'b0;
    if (t && w) begin
      if (pq == 2'b00) begin nx = 2'b10; f = 1'b1; end
      else if (pq == 2'b10) nx = 2'b11;
    end else if (!t && ((w && o == O_ST) || (!w && o == O_LD))) begin
      if (pq == 2'b10) nx = 2'b00;
      else if (pq == 2'b11) begin nx = 2'b10; f = 1'b1; end
    end else if (!t && !w && o == O_UM) nx = 2'b00;
    else if (!t && !w && o == O_MK) nx = 2'b01;
    return {f, nx};
  endfunction

  task automatic access(input int s, input logic w, input logic t,
                        input logic [11:0] o, input string tag);
    logic [2:0] m = model(exp_pq[s], w, t, o);
    logic [1:0] old = exp_pq[s];
    @(negedge clk);
    req = 1; wr = w; tp = t; src = SW'(s); off = o;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    chk(rsp_v == !w, {tag, " rsp_valid"}, rsp_v, !w);
    if (!w) chk(rsp_pq == old, {tag, " rsp_pq"}, rsp_pq, old);
    chk(fwd == m[2], {tag, " fwd"}, fwd, m[2]);
    if (m[2]) chk(fwd_src == SW'(s), {tag, " fwd_src"}, fwd_src, s);
    exp_pq[s] = m[1:0];
  endtask

  task automatic peek(input int s, input string tag);
    access(s, 1'b0, 1'b0, O_PK, tag);
  endtask

  task automatic t_reset;
    chk(rsp_v == 0, "R1 rsp_valid idle", rsp_v, 0);
    chk(fwd == 0, "R1 fwd idle", fwd, 0);
    for (int i = 0; i < N; i++) peek(i, "R1 reset state");
  endtask

  task automatic t_trigger;
    access(2, 1, 1, O_ST, "R2 trig masked");
    access(2, 0, 0, O_UM, "R3 unmask");
    access(2, 1, 1, 12'h123, "R2 trig idle");
    @(negedge clk);
    chk(fwd == 0, "R8 fwd single pulse", fwd, 0);
    chk(rsp_v == 0, "R8 rsp single pulse", rsp_v, 0);
    access(2, 1, 1, O_ST, "R2 trig pending");
    access(2, 1, 1, O_PK, "R2 trig queued");
    peek(2, "R2 state 11");
  endtask

  task automatic t_store_eoi;
    access(2, 1, 0, O_ST, "R5 store eoi 11");
    access(2, 1, 0, O_ST, "R5 store eoi 10");
    access(2, 1, 0, O_ST, "R5 store eoi 00");
    peek(2, "R5 state 00");
  endtask

  task automatic t_load_eoi;
    access(5, 0, 0, O_UM, "R6 unmask");
    access(5, 1, 1, O_ST, "R6 trig");
    access(5, 1, 1, O_ST, "R6 trig dup");
    access(5, 0, 0, O_LD, "R6 load eoi 11");
    access(5, 0, 0, O_LD, "R6 load eoi 10");
    access(5, 0, 0, O_LD, "R6 load eoi 00");
  endtask

  task automatic t_mask;
    access(5, 1, 1, O_ST, "R4 trig");
    access(5, 0, 0, O_MK, "R4 mask");
    access(5, 1, 1, O_ST, "R4 trig after mask");
    access(5, 0, 0, O_LD, "R4 eoi while masked");
    peek(5, "R4 state 01");
  endtask

  task automatic t_sw_eoi_q;
    access(3, 0, 0, O_UM, "R3 unmask");
    access(3, 1, 1, O_ST, "R3 trig");
    access(3, 1, 1, O_ST, "R3 trig dup");
    access(3, 0, 0, O_UM, "R3 sw eoi Q set");
    chk(rsp_pq[0] == 1, "R3 returned Q", rsp_pq[0], 1);
    access(3, 1, 1, O_ST, "R3 retrigger");
  endtask

  task automatic t_ignored;
    access(2, 1, 0, O_UM, "R7 store at C00");
    access(2, 1, 0, O_MK, "R7 store at D00");
    access(2, 1, 0, O_PK, "R7 store at 800");
    access(2, 0, 1, O_ST, "R7 load trig page");
    peek(2, "R7 state kept");
  endtask

  task automatic t_independent;
    access(7, 0, 0, O_UM, "R9 unmask other");
    access(7, 1, 1, O_ST, "R9 trig other");
    access(6, 1, 1, O_ST, "R9 trig masked other");
    peek(2, "R9 src2 kept");
    peek(3, "R9 src3 kept");
    peek(0, "R9 src0 kept");
  endtask

  initial begin
    for (int i = 0; i < N; i++) exp_pq[i] = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_trigger;
    t_store_eoi;
    t_load_eoi;
    t_mask;
    t_sw_eoi_q;
    t_ignored;
    t_independent;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule